// File: doc/BRIEF.md
# Heartbeat Inactivity Watchdog

This block watches a heartbeat line that a processor toggles in software while it runs normally. Each change of level on the line, rising or falling, restarts an idle counter. If the line holds one level for longer than a set number of clock cycles, the block pulls its active-low watchdog flag low. The system decides whether that flag drives an interrupt or a reset.

The heartbeat is asynchronous to the clock. It passes through a synchronizer, and the block then compares each synchronized value with the one before it. The counter stays at zero while the system reset status is active. Timing therefore starts only after reset is released. A supply-good flag gates the output directly. While the supply is low, the flag is low whatever the count. When the supply recovers, the flag rises in the same cycle. The timeout length is a parameter in cycles. Its default stands for 1.6 s at 125 MHz, and a simulation can use a much smaller value.

Top module: `hb_watchdog`

## Requirements
- R1: When the synchronized heartbeat holds one level, `wdt_n_o` goes low in the cycle the idle counter reaches WDT_CYCLES. With a level change on `hb_i` sampled at clock edge n, the flag is first low after edge n+2+WDT_CYCLES, assuming supply good and no reset.
- R2: A rising change and a falling change on the heartbeat both return the idle counter to zero. When the heartbeat changes at intervals shorter than the timeout, the flag never goes low.
- R3: After a timeout the flag stays low until a heartbeat change clears the counter. With that change sampled at edge n, the flag is high again after edge n+2.
- R4: While `sys_rst_i` is high (active high, sampled on the clock), the counter and the synchronizer are held at zero and no timeout can occur. A full timeout period is counted again from release.
- R5: While `supply_ok_i` is low, `wdt_n_o` is low, whatever the count.
- R6: When `supply_ok_i` returns high and no timeout is pending, `wdt_n_o` is high in the same cycle, with no delay from a register.
- R7: A heartbeat pulse one clock period wide is seen as two changes, and each of them clears the counter.
- R8: The counter saturates at WDT_CYCLES and never wraps. After an idle time several times the timeout, the flag is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| sys_rst_i | input | 1 | System reset status, active high; holds the timer clear |
| hb_i | input | 1 | Asynchronous heartbeat from the processor |
| supply_ok_i | input | 1 | Supply above threshold when high |
| wdt_n_o | output | 1 | Watchdog flag, low on timeout or undervoltage |

## Verification
The embedded assertions check four properties on every cycle: the counter is cleared after a reset cycle and after a detected heartbeat change, it never exceeds the limit, and a saturated count holds until it is cleared. The bench's scenarios are the only way to show the end-to-end latencies: the exact cycle in which the flag falls after the last heartbeat change, the two-cycle recovery after a late change, the same-cycle response to the supply flag, the detection of a one-cycle pulse, and a full timeout counted again after a reset in the middle of a run. A behavioural reference model compares the flag on every cycle as well.

// File: rtl/hbw_pkg.sv
package hbw_pkg;
  // Bits needed to hold the values 0..n inclusive.
  function automatic int unsigned count_width(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((64'd1 << w) <= 64'(n)) w++;
    return w;
  endfunction

  localparam int unsigned HBW_SYNC_STAGES = 2;
endpackage

// File: rtl/hbw_sync.sv
module hbw_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i) begin
          if (clr_i) chain[0] <= 1'b0;
          else       chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i) begin
          if (clr_i) chain[s] <= 1'b0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hbw_edge_detect.sv
module hbw_edge_detect (
  input  logic clk_i,
  input  logic clr_i,
  input  logic lvl_i,
  output logic chg_o
);
  logic lvl_q;

  always_ff @(posedge clk_i) begin
    if (clr_i) lvl_q <= 1'b0;
    else       lvl_q <= lvl_i;
  end

  // Either direction of change counts.
  assign chg_o = lvl_i ^ lvl_q;
endmodule

// File: rtl/hbw_idle_counter.sv
module hbw_idle_counter #(
  parameter int unsigned LIMIT_CYCLES = 40,
  parameter int unsigned CW           = 6
) (
  input  logic          clk_i,
  input  logic          clr_i,
  input  logic          kick_i,
  output logic [CW-1:0] cnt_o,
  output logic          expired_o
);
  localparam logic [CW-1:0] LIMIT = CW'(LIMIT_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (clr_i || kick_i)    cnt_q <= '0;
    else if (cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign expired_o = (cnt_q == LIMIT);

  AST_CLEAR_IN_RESET: assert property (@(posedge clk_i) clr_i |=> (cnt_q == '0)); // R4
  AST_KICK_CLEARS: assert property (@(posedge clk_i) disable iff (clr_i)
    kick_i |=> (cnt_q == '0)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (clr_i)
    cnt_q <= LIMIT); // R8
  AST_TIMEOUT_STICKY: assert property (@(posedge clk_i) disable iff (clr_i)
    (expired_o && !kick_i) |=> expired_o); // R3
endmodule

// File: rtl/hb_watchdog.sv
module hb_watchdog #(
  parameter int unsigned WDT_CYCLES = 200_000_000
) (
  input  logic clk_i,
  input  logic sys_rst_i,
  input  logic hb_i,
  input  logic supply_ok_i,
  output logic wdt_n_o
);
  import hbw_pkg::*;

  localparam int unsigned CW = count_width(WDT_CYCLES);

  logic          hb_sync;
  logic          hb_chg;
  logic [CW-1:0] idle_cnt;
  logic          idle_expired;

  hbw_sync #(.STAGES(HBW_SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .clr_i (sys_rst_i),
    .d_i   (hb_i),
    .q_o   (hb_sync)
  );

  hbw_edge_detect u_edge (
    .clk_i (clk_i),
    .clr_i (sys_rst_i),
    .lvl_i (hb_sync),
    .chg_o (hb_chg)
  );

  hbw_idle_counter #(.LIMIT_CYCLES(WDT_CYCLES), .CW(CW)) u_cnt (
    .clk_i     (clk_i),
    .clr_i     (sys_rst_i),
    .kick_i    (hb_chg),
    .cnt_o     (idle_cnt),
    .expired_o (idle_expired)
  );

  // Supply gating is combinational so recovery is seen in the same cycle.
  assign wdt_n_o = supply_ok_i & ~idle_expired;

  AST_UV_FLAG_LOW: assert property (@(posedge clk_i) disable iff (sys_rst_i)
    (!supply_ok_i) |-> !wdt_n_o); // R5
endmodule

// File: tb/hb_watchdog_tb.sv
module hb_watchdog_tb;
  localparam int unsigned LIM = 40;

  logic clk = 1'b0;
  logic sys_rst = 1'b1;
  logic hb = 1'b0;
  logic supply_ok = 1'b1;
  logic wdt_n;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string phase = "R4";

  // Reference model state.
  int model_cnt = 0;
  bit hist[$] = '{1'b0, 1'b0, 1'b0};

  always #4 clk = ~clk;

  hb_watchdog #(.WDT_CYCLES(LIM)) u_dut (
    .clk_i       (clk),
    .sys_rst_i   (sys_rst),
    .hb_i        (hb),
    .supply_ok_i (supply_ok),
    .wdt_n_o     (wdt_n)
  );

  always @(posedge clk) begin
    cycles++;
    if (sys_rst) begin
      model_cnt = 0;
      hist = '{1'b0, 1'b0, 1'b0};
    end else begin
      if (hist[1] != hist[0]) model_cnt = 0;
      else if (model_cnt < LIM) model_cnt++;
      hist.push_back(hb);
      void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    logic exp_n;
    exp_n = supply_ok && (model_cnt != LIM);
    checks++;
    if (wdt_n !== exp_n) begin
      failures++;
      $display("FAIL %s per-cycle flag act=%0b exp=%0b at cycle %0d", phase, wdt_n, exp_n, cycles);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // Count posedges, including the one that samples the prior change, until the flag matches want.
  task automatic wait_flag(input logic want, output int k);
    k = 0;
    do begin
      @(posedge clk); k++;
      @(negedge clk);
    end while (wdt_n !== want && k < 4 * LIM);
    #(2);
  endtask

  initial begin
    int k;
    #2;
    // R4: reset held far longer than the timeout.
    step(3 * LIM);
    @(negedge clk);
    check(wdt_n === 1'b1, "R4 flag high during long reset", wdt_n, 1);
    #2; sys_rst = 1'b0;
    step(5);

    // R1: timeout latency after a change.
    phase = "R1";
    hb = ~hb;
    wait_flag(1'b0, k);
    check(k == LIM + 3, "R1 timeout latency", k, LIM + 3);

    // R3 and R8: sticky, saturated.
    phase = "R8";
    step(3 * LIM);
    @(negedge clk);
    check(wdt_n === 1'b0, "R8 still low after long idle", wdt_n, 0);
    check(wdt_n === 1'b0, "R3 held low until cleared", wdt_n, 0);
    #2;
    phase = "R3";
    hb = ~hb;
    wait_flag(1'b1, k);
    check(k == 3, "R3 recovery latency", k, 3);

    // R2: regular toggling, alternating rising and falling.
    phase = "R2";
    for (int i = 0; i < 8; i++) begin
      step(LIM - 10);
      hb = ~hb;
    end
    @(negedge clk);
    check(wdt_n === 1'b1, "R2 regular toggling never times out", wdt_n, 1);
    #2;
    // Falling change alone clears.
    hb = 1'b1; step(LIM - 5);
    hb = 1'b0; step(LIM - 5);
    @(negedge clk);
    check(wdt_n === 1'b1, "R2 falling change clears", wdt_n, 1);
    #2;
    hb = 1'b1; step(LIM - 5);
    @(negedge clk);
    check(wdt_n === 1'b1, "R2 rising change clears", wdt_n, 1);
    #2;

    // R7: one-cycle pulse near timeout.
    phase = "R7";
    step(LIM - 10);
    hb = 1'b0; step(1); hb = 1'b1;
    step(LIM - 5);
    @(negedge clk);
    check(wdt_n === 1'b1, "R7 one-cycle pulse detected", wdt_n, 1);
    #2;
    wait_flag(1'b0, k);
    check(wdt_n === 1'b0, "R7 timeout after pulse then idle", wdt_n, 0);

    // R5: undervoltage forces low even with a fresh count.
    phase = "R5";
    hb = ~hb; step(4);
    supply_ok = 1'b0;
    @(negedge clk);
    check(wdt_n === 1'b0, "R5 undervoltage forces low", wdt_n, 0);
    #2; step(5);
    @(negedge clk);
    check(wdt_n === 1'b0, "R5 stays low during undervoltage", wdt_n, 0);
    #2;
    // R6: immediate recovery, checked before the next edge.
    phase = "R6";
    supply_ok = 1'b1;
    #1;
    check(wdt_n === 1'b1, "R6 same-cycle recovery", wdt_n, 1);
    step(1);

    // R4: reset in the middle of a run restarts the full period.
    phase = "R4";
    hb = ~hb; step(LIM - 5);
    sys_rst = 1'b1; step(3);
    sys_rst = 1'b0; step(LIM - 5);
    @(negedge clk);
    check(wdt_n === 1'b1, "R4 reset restarts timing", wdt_n, 1);
    #2;
    step(3 * LIM);
    @(negedge clk);
    check(wdt_n === 1'b0, "R1 timeout after reset release", wdt_n, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule